// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block orders the handshake that moves a system between full, one-half and one-thirty-second clock speed. Software writes a one-hot request code into a control field. A fresh rising edge on a single legal bit starts a sequence. The block pulls freeze low and waits for the freeze acknowledge. It then asserts the active-low clock-change lines, raises PLL bypass, releases the clock-change lines, and finally lets bypass and freeze go. Each of these steps waits for its own programmable delay. All delays are counted in block clocks, which run at half the system frequency.

The PLLs and clock generators sit outside this block. They watch the freeze, clock-change and bypass outputs. Other logic reads the frequency code that is in force and the busy flag. Software is expected to clear the control field about 16 system clocks (8 block clocks) after setting it. Only a new 0-to-1 transition can start a further change.

Top module: `clkseq`

## Requirements
- R1: After reset, freeze_n is 1, every chg_n line is 1, pll_bypass is 0, busy is 0 and cur_code is the full-speed code 0x01.
- R2: While idle, if the request field rises from 0 to 1 on exactly one of the legal bits, freeze_n goes low and busy goes high one clock later. The legal bits are 0x01 (full), 0x02 (half) and 0x20 (1/32). The rise counts only if the whole field then holds that single bit.
- R3: A field with more than one bit set, a reserved bit (mask 0xDC, or 0x80), or a value with no new rising bit starts nothing. freeze_n stays 1 and busy stays 0.
- R4: freeze_n stays low until freeze_ack is sampled high. The chg_n lines go low max(dly_achg,1) clocks after the edge that samples the acknowledge.
- R5: pll_bypass goes high max(dly_abyp,1) clocks after the chg_n lines go low.
- R6: The chg_n lines return high max(dly_dchg,1) clocks after pll_bypass goes high.
- R7: Two releases are timed independently from the clock where chg_n returns high. pll_bypass drops max(dly_dbyp,1) clocks after it, and freeze_n returns high max(dly_settle,1) clocks after it.
- R8: busy drops once both bypass and freeze are released. cur_code takes the requested code on that same clock and changes at no other time.
- R9: A request that rises while busy is ignored. It starts nothing afterwards either.
- R10: A delay value of zero behaves as a delay of one clock.
- R11: All chg_n lines switch together, and they are only ever low while freeze_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (half system frequency) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_code | input | 8 | Software request field, one-hot code |
| dly_achg | input | 8 | Acknowledge to clock-change assert delay |
| dly_abyp | input | 16 | Clock-change assert to bypass assert delay |
| dly_dchg | input | 8 | Bypass assert to clock-change release delay |
| dly_dbyp | input | 8 | Clock-change release to bypass release delay |
| dly_settle | input | 32 | Clock-change release to unfreeze delay (PLL settle) |
| freeze_ack | input | 1 | Freeze acknowledge from the system |
| freeze_n | output | 1 | Active-low freeze |
| chg_n | output | 3 | Active-low clock-change lines |
| pll_bypass | output | 1 | PLL bypass |
| busy | output | 1 | Sequence in progress |
| cur_code | output | 8 | Frequency code currently in force |

## Verification
Every output here is decoded from registered state, so each result appears just after a rising edge. The bench drives inputs and samples outputs on falling edges, and numbers the falling edges from the one where the request is written. Freeze is due on edge 1. Each later event is due a fixed count of edges after the one before it: the acknowledge is sampled one edge after it is driven, then max(delay,1) for each phase. The bench records the first falling edge at which each output changes and checks the differences against those sums. It also checks the code and busy state once the sequence has finished.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FRZ    = 3'd1,
      ST_ACHG   = 3'd2,
      ST_ABYP   = 3'd3,
      ST_DCHG   = 3'd4,
      ST_SETTLE = 3'd5
   } seq_state_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkseq_trig.sv
module clkseq_trig #(
   parameter int            CW    = 8,
   parameter logic [CW-1:0] LEGAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] req,
   output logic          fire
);
   logic [CW-1:0] req_q;
   logic [CW-1:0] rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req;
   end

   assign rise = req & ~req_q;
   // one new bit, nothing else set in the field, and that bit is legal
   assign fire = $onehot(rise) && (rise == req) && ((rise & ~LEGAL) == '0);

endmodule

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
   parameter int CW = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   output logic [CW:0] elapsed
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign elapsed = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};

   // a phase always ends before its counter could wrap back to zero (R7)
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (cnt != '0));

endmodule

// File: rtl/clkseq.sv
module clkseq #(
   parameter int              CODE_W    = 8,
   parameter logic [CODE_W-1:0] CODE_FULL = 8'h01,
   parameter logic [CODE_W-1:0] CODE_HALF = 8'h02,
   parameter logic [CODE_W-1:0] CODE_SLOW = 8'h20,
   parameter int              CHG_LINES = 3,
   parameter int              ACHG_W    = 8,
   parameter int              ABYP_W    = 16,
   parameter int              DCHG_W    = 8,
   parameter int              DBYP_W    = 8,
   parameter int              SETTLE_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CODE_W-1:0]    req_code,
   input  logic [ACHG_W-1:0]    dly_achg,
   input  logic [ABYP_W-1:0]    dly_abyp,
   input  logic [DCHG_W-1:0]    dly_dchg,
   input  logic [DBYP_W-1:0]    dly_dbyp,
   input  logic [SETTLE_W-1:0]  dly_settle,
   input  logic                 freeze_ack,
   output logic                 freeze_n,
   output logic [CHG_LINES-1:0] chg_n,
   output logic                 pll_bypass,
   output logic                 busy,
   output logic [CODE_W-1:0]    cur_code
);
   import clkseq_pkg::*;

   localparam logic [CODE_W-1:0] LEGAL = CODE_FULL | CODE_HALF | CODE_SLOW;
   localparam int CW = imax(imax(imax(ACHG_W, ABYP_W), imax(DCHG_W, DBYP_W)), SETTLE_W);

   // ---------------- elaboration checks ----------------
   if ($countones(CODE_FULL) != 1 || $countones(CODE_HALF) != 1 ||
       $countones(CODE_SLOW) != 1) begin : g_bad_code
      $error("clkseq: each frequency code must be one-hot");
   end
   if ($countones(LEGAL) != 3) begin : g_bad_overlap
      $error("clkseq: frequency codes must be distinct");
   end
   if (CHG_LINES < 1 || ACHG_W < 1 || ABYP_W < 1 || DCHG_W < 1 ||
       DBYP_W < 1 || SETTLE_W < 1) begin : g_bad_width
      $error("clkseq: widths and line count must be positive");
   end

   // ---------------- request detection ----------------
   logic fire;
   clkseq_trig #(.CW(CODE_W), .LEGAL(LEGAL)) u_trig (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_code),
      .fire (fire)
   );

   // ---------------- phase timer ----------------
   seq_state_t    state, state_nxt;
   logic          tmr_clear;
   logic [CW:0]   elapsed;

   clkseq_timer #(.CW(CW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (tmr_clear),
      .elapsed(elapsed)
   );

   logic [CW:0] tgt, byp_tgt, frz_tgt;
   logic        byp_hit, frz_hit, byp_done, frz_done;
   logic [CODE_W-1:0] pend;

   always_comb begin
      byp_tgt = '0;
      frz_tgt = '0;
      byp_tgt[DBYP_W-1:0]   = dly_dbyp;
      frz_tgt[SETTLE_W-1:0] = dly_settle;
   end
   assign byp_hit = (elapsed >= byp_tgt);
   assign frz_hit = (elapsed >= frz_tgt);

   // ---------------- sequencing ----------------
   always_comb begin
      state_nxt = state;
      tgt       = '0;
      unique case (state)
         ST_IDLE:   if (fire) state_nxt = ST_FRZ;
         ST_FRZ:    if (freeze_ack) state_nxt = ST_ACHG;
         ST_ACHG: begin
            tgt[ACHG_W-1:0] = dly_achg;
            if (elapsed >= tgt) state_nxt = ST_ABYP;
         end
         ST_ABYP: begin
            tgt[ABYP_W-1:0] = dly_abyp;
            if (elapsed >= tgt) state_nxt = ST_DCHG;
         end
         ST_DCHG: begin
            tgt[DCHG_W-1:0] = dly_dchg;
            if (elapsed >= tgt) state_nxt = ST_SETTLE;
         end
         ST_SETTLE:
            if ((byp_done || byp_hit) && (frz_done || frz_hit)) state_nxt = ST_IDLE;
         default:   state_nxt = ST_IDLE;
      endcase
   end

   assign tmr_clear = (state_nxt != state) || (state == ST_IDLE) || (state == ST_FRZ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= CODE_FULL;
         cur_code <= CODE_FULL;
         byp_done <= 1'b0;
         frz_done <= 1'b0;
      end else begin
         state <= state_nxt;
         if (state == ST_IDLE && fire) pend <= req_code;
         if (state == ST_SETTLE) begin
            byp_done <= byp_done | byp_hit;
            frz_done <= frz_done | frz_hit;
            if (state_nxt == ST_IDLE) cur_code <= pend;
         end else begin
            byp_done <= 1'b0;
            frz_done <= 1'b0;
         end
      end
   end

   // ---------------- outputs ----------------
   logic chg_act;
   assign chg_act    = (state == ST_ABYP) || (state == ST_DCHG);
   assign pll_bypass = (state == ST_DCHG) || (state == ST_SETTLE && !byp_done);
   assign freeze_n   = (state == ST_IDLE) || (state == ST_SETTLE && frz_done);
   assign busy       = (state != ST_IDLE);

   for (genvar g = 0; g < CHG_LINES; g++) begin : g_chg
      assign chg_n[g] = ~chg_act;
   end

   // ---------------- assertions ----------------
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && fire) |=> (!freeze_n && busy));

   p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !fire) |=> (!busy && freeze_n));

   p_wait_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRZ && !freeze_ack) |=> (!freeze_n && chg_n == '1));

   p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_SETTLE) |=> $stable(cur_code));

   p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(cur_code) && ((cur_code & ~LEGAL) == '0));

   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != ST_SETTLE) |=> busy);

   p_lines_together_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chg_n) == 0) || ($countones(chg_n) == CHG_LINES));

   p_chg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_n != '1) |-> !freeze_n);

endmodule

// File: tb/clkseq_test.sv
module clkseq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req_code = 8'h00;
   logic [7:0]  dly_achg = 8'd0;
   logic [15:0] dly_abyp = 16'd0;
   logic [7:0]  dly_dchg = 8'd0;
   logic [7:0]  dly_dbyp = 8'd0;
   logic [31:0] dly_settle = 32'd0;
   logic        freeze_ack = 1'b0;
   logic        freeze_n;
   logic [2:0]  chg_n;
   logic        pll_bypass;
   logic        busy;
   logic [7:0]  cur_code;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   clkseq uut (
      .clk(clk), .rst_n(rst_n), .req_code(req_code),
      .dly_achg(dly_achg), .dly_abyp(dly_abyp), .dly_dchg(dly_dchg),
      .dly_dbyp(dly_dbyp), .dly_settle(dly_settle), .freeze_ack(freeze_ack),
      .freeze_n(freeze_n), .chg_n(chg_n), .pll_bypass(pll_bypass),
      .busy(busy), .cur_code(cur_code)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int mx1(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   function automatic logic [7:0] code_of(input int k);
      case (k % 3)
         0:       return 8'h01;
         1:       return 8'h02;
         default: return 8'h20;
      endcase
   endfunction

   task automatic idle_req(input logic [7:0] v, input string tag);
      @(negedge clk);
      req_code = v;
      repeat (3) @(negedge clk);
      chk({tag, " busy"}, busy, 0);
      chk({tag, " freeze_n"}, freeze_n, 1);
   endtask

   task automatic run_seq(input logic [7:0] code, input int dac, input int dab,
                          input int ddc, input int ddb, input int dst,
                          input int lat, input bit intrude, input string tg);
      int n = 0;
      int t_ff = -1, t_ack = -1, t_chg = -1, t_choff = -1;
      int t_byp = -1, t_bypoff = -1, t_frzoff = -1, t_idle = -1;
      logic [7:0] alt = (code == 8'h01) ? 8'h20 : 8'h01;
      @(negedge clk);
      req_code   = 8'h00;
      dly_achg   = 8'(dac);
      dly_abyp   = 16'(dab);
      dly_dchg   = 8'(ddc);
      dly_dbyp   = 8'(ddb);
      dly_settle = 32'(dst);
      repeat (2) @(negedge clk);
      req_code = code;
      while (n < 5000) begin
         @(negedge clk);
         n++;
         if (t_ff < 0 && !freeze_n) t_ff = n;
         if (t_chg < 0 && chg_n == 3'b000) t_chg = n;
         if (t_chg >= 0 && t_choff < 0 && chg_n == 3'b111) t_choff = n;
         if (t_byp < 0 && pll_bypass) t_byp = n;
         if (t_byp >= 0 && t_bypoff < 0 && !pll_bypass) t_bypoff = n;
         if (t_chg >= 0 && t_frzoff < 0 && freeze_n) t_frzoff = n;
         if (t_ff >= 0 && t_idle < 0 && !busy) begin
            t_idle = n;
            break;
         end
         if (t_ff >= 0 && t_ack < 0 && n == t_ff + lat) begin
            freeze_ack = 1'b1;
            t_ack = n;
         end
         if (intrude) begin
            if (t_ff >= 0 && n == t_ff + 1) req_code = 8'h00;
            if (t_ff >= 0 && n == t_ff + 2) req_code = alt;
         end else if (n == 8) begin
            req_code = 8'h00;   // software clear after 16 system clocks
         end
      end
      freeze_ack = 1'b0;
      chk({tg, " R2 freeze start"}, t_ff, 1);
      chk({tg, " R4 ack to chg"}, t_chg - t_ack, 1 + mx1(dac));
      chk({tg, " R5 chg to bypass"}, t_byp - t_chg, mx1(dab));
      chk({tg, " R6 bypass to chg release"}, t_choff - t_byp, mx1(ddc));
      chk({tg, " R7 bypass release"}, t_bypoff - t_choff, mx1(ddb));
      chk({tg, " R7 freeze release"}, t_frzoff - t_choff, mx1(dst));
      chk({tg, " R8 busy end"}, t_idle - t_choff,
          (mx1(ddb) > mx1(dst)) ? mx1(ddb) : mx1(dst));
      chk({tg, " R8 code"}, cur_code, code);
      if (intrude) begin
         repeat (4) @(negedge clk);
         chk({tg, " R9 busy after"}, busy, 0);
         chk({tg, " R9 freeze after"}, freeze_n, 1);
         chk({tg, " R9 code after"}, cur_code, code);
      end
      @(negedge clk);
      req_code = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state, during and after reset
      chk("R1 freeze_n in reset", freeze_n, 1);
      chk("R1 chg_n in reset", chg_n, 7);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 bypass", pll_bypass, 0);
      chk("R1 busy", busy, 0);
      chk("R1 cur_code", cur_code, 8'h01);

      // R3 invalid requests
      idle_req(8'h03, "R3 two legal bits");
      idle_req(8'h00, "R3 clear");
      idle_req(8'h04, "R3 reserved bit 0x04");
      idle_req(8'h00, "R3 clear");
      idle_req(8'h80, "R3 reserved bit 0x80");
      idle_req(8'h00, "R3 clear");
      idle_req(8'hDC, "R3 reserved mask");
      idle_req(8'h00, "R3 clear");
      idle_req(8'h21, "R3 two bits rising");
      idle_req(8'h20, "R3 no new rise");
      idle_req(8'h21, "R3 single rise but two bits");
      idle_req(8'h00, "R3 clear");
      chk("R3 code untouched", cur_code, 8'h01);

      // R10 all-zero delays behave as one
      run_seq(8'h20, 0, 0, 0, 0, 0, 0, 1'b0, "R10 zero");

      // sweep over codes, delays, acknowledge latency and intrusion
      for (int i = 0; i < 36; i++) begin
         run_seq(code_of(i), i % 4, (i / 4) % 3, i % 3, (i * 5) % 4,
                 (i * 7) % 5, i % 4, (i % 5) == 0, "sweep");
      end

      // long phases, bypass release after and before unfreeze
      run_seq(8'h02, 20, 300, 5, 200, 40, 6, 1'b1, "long a");
      run_seq(8'h20, 3, 2, 7, 9, 250, 2, 1'b0, "long b");
      run_seq(8'h01, 1, 1, 1, 1, 1, 1, 1'b1, "unit");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule